// File: doc/BRIEF.md
# Instruction-Cache Tag Directory

This block keeps only the address tags and replacement state of a set-associative instruction cache. Every fetch address it is given is classified as a hit or a miss against the indexed set. A miss installs the new tag in a victim way. Small saturating usage counters, one per way, pick that victim, and a per-way enable mask limits which counters may age on a miss. An invalidate request clears a matching way, but only if the mask enables that way. A lock request is accepted and then dropped with no effect. The block returns a one-cycle hit or miss pulse for each lookup, and it keeps running 32-bit totals of hits and misses.

Requests enter through three command registers: lookup, invalidate and lock. Each register holds an address, and an all-zero address means the register is empty. The registers are loaded through a valid/ready handshake and are serviced and emptied on the next clock. When a lookup and an invalidate are serviced on the same clock, the lookup is applied first and the invalidate sees its result. Line size, set count, way count, counter states and counter width are all parameters.

Top module: `icache_tag_dir`

## Requirements
- R1: After the synchronous reset: both totals are zero, both pulses are low, every stored tag is all ones, and every usage counter is zero. A first lookup of any address whose tag is not all ones therefore misses.
- R2: The low log2(line bytes) address bits are ignored. The next log2(sets) bits select the set, and all remaining upper bits form the tag.
- R3: A lookup hits when any way of the indexed set holds the tag. If several ways match, the highest-numbered one is used. On a hit, every nonzero counter in the set drops by one, and the hit way's counter is then loaded with (states - 1).
- R4: On a miss, the victim is the highest-numbered way whose counter is below (states - 1). If no way qualifies, the victim is way 0. The victim's tag is replaced with the new tag.
- R5: On a miss, a counter drops by one only if it is nonzero and its way is set in way_enable. The victim's counter is then loaded with (states - 1), whatever the mask says.
- R6: A lookup is serviced only when cache_present and cache_enable are both high on its service clock. Otherwise it produces no pulse and changes no tag, counter or total.
- R7: An invalidate needs only cache_present. It finds the highest matching way and sets that way's tag to all ones, but only if that way is set in way_enable. In every other case it changes nothing.
- R8: cmd_ready is low during reset and high afterwards. A request with valid and ready high at a rising edge is loaded into its command register. A request with address zero is dropped. A loaded lookup gives exactly one hit_pulse or miss_pulse, one clock wide, on the following edge. Each command register is empty after every clock on which nothing new is loaded.
- R9: When a lookup and an invalidate are serviced on the same clock and address the same set, the invalidate acts on the tags as the lookup left them.
- R10: A lock request is accepted and cleared. It gives no pulse and changes no tag, counter or total.
- R11: hit_count and miss_count rise by one with each hit_pulse and miss_pulse respectively. Each is CNT_W bits wide (32 by default) and holds at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_present | input | 1 | Cache exists; required by lookups and invalidates |
| cache_enable | input | 1 | Cache switched on; required by lookups |
| way_enable | input | NUM_WAYS | Per-way mask for miss aging and invalidation |
| cmd_ready | output | 1 | Command registers accept requests |
| fetch_valid | input | 1 | Lookup request valid |
| fetch_addr | input | ADDR_W | Lookup byte address |
| inval_valid | input | 1 | Invalidate request valid |
| inval_addr | input | ADDR_W | Invalidate byte address |
| lock_valid | input | 1 | Lock request valid (no effect) |
| lock_addr | input | ADDR_W | Lock byte address |
| hit_pulse | output | 1 | One-cycle hit indication |
| miss_pulse | output | 1 | One-cycle miss indication |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |

## Verification
The assertions check several properties on every clock. The two pulses are never high together. A pulse only follows a lookup that was pending while both flags were high. Unloaded command registers come back empty. The totals step by exactly one per event, or hold once they are saturated. Only the bench scenarios can show the replacement decisions, because those appear only as hit or miss results of later lookups. These cover victim choice, aging masked by way_enable, the masked invalidate, the lookup-before-invalidate ordering and the lock having no effect.

// File: rtl/icd_pkg.sv
package icd_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2
  } lk_res_e;
endpackage

// File: rtl/icd_addr_split.sv
module icd_addr_split #(
  parameter int LINE_W = 28,
  parameter int IDX_W  = 9,
  localparam int TAG_W = LINE_W - IDX_W
) (
  input  logic [LINE_W-1:0] line_addr,
  output logic [IDX_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag
);
  // low bits of the line number pick the set, the rest is the tag
  assign set_idx = line_addr[IDX_W-1:0];
  assign tag     = line_addr[LINE_W-1:IDX_W];
endmodule

// File: rtl/icd_lookup.sv
module icd_lookup
  import icd_pkg::*;
#(
  parameter int NUM_WAYS   = 1,
  parameter int TAG_W      = 19,
  parameter int CTR_W      = 1,
  parameter int USE_STATES = 2
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags_in,
  input  logic [NUM_WAYS-1:0][CTR_W-1:0] ctrs_in,
  input  logic [TAG_W-1:0]               tag,
  input  logic [NUM_WAYS-1:0]            way_en,
  output lk_res_e                        res,
  output logic [NUM_WAYS-1:0][TAG_W-1:0] tags_out,
  output logic [NUM_WAYS-1:0][CTR_W-1:0] ctrs_out
);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam logic [CTR_W-1:0] TOP_ST = CTR_W'(USE_STATES - 1);

  logic [NUM_WAYS-1:0] match;
  logic                hit_any;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    vic_way;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = (tags_in[w] == tag);
  end

  // highest matching way and highest aged way win
  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (match[w]) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (ctrs_in[w] < TOP_ST) vic_way = WAY_W'(w);
    end
  end

  always_comb begin
    tags_out = tags_in;
    ctrs_out = ctrs_in;
    if (hit_any) begin
      for (int w = 0; w < NUM_WAYS; w++)
        if (ctrs_in[w] != '0) ctrs_out[w] = ctrs_in[w] - CTR_W'(1);
      ctrs_out[hit_way] = TOP_ST;
      res = LK_HIT;
    end else begin
      tags_out[vic_way] = tag;
      for (int w = 0; w < NUM_WAYS; w++)
        if (ctrs_in[w] != '0 && way_en[w]) ctrs_out[w] = ctrs_in[w] - CTR_W'(1);
      ctrs_out[vic_way] = TOP_ST;
      res = LK_MISS;
    end
  end
endmodule

// File: rtl/icd_inval.sv
module icd_inval #(
  parameter int NUM_WAYS = 1,
  parameter int TAG_W    = 19
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags_in,
  input  logic [TAG_W-1:0]               tag,
  input  logic [NUM_WAYS-1:0]            way_en,
  output logic [NUM_WAYS-1:0][TAG_W-1:0] tags_out
);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  logic             found;
  logic [WAY_W-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (tags_in[w] == tag) begin
        found = 1'b1;
        sel   = WAY_W'(w);
      end
    tags_out = tags_in;
    // only the chosen way is considered, and only when the mask allows it
    if (found && way_en[sel]) tags_out[sel] = '1;
  end
endmodule

// File: rtl/icd_sat_cnt.sv
module icd_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != '1) count <= count + CNT_W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && count != '1) |=> (count == $past(count) + CNT_W'(1))); // R11
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc || count == '1) |=> $stable(count)); // R11
endmodule

// File: rtl/icache_tag_dir.sv
module icache_tag_dir
  import icd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 512,
  parameter int LINE_BYTES = 16,
  parameter int NUM_WAYS   = 1,
  parameter int USE_STATES = 2,
  parameter int CNT_W      = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cache_present,
  input  logic                cache_enable,
  input  logic [NUM_WAYS-1:0] way_enable,
  output logic                cmd_ready,
  input  logic                fetch_valid,
  input  logic [ADDR_W-1:0]   fetch_addr,
  input  logic                inval_valid,
  input  logic [ADDR_W-1:0]   inval_addr,
  input  logic                lock_valid,
  input  logic [ADDR_W-1:0]   lock_addr,
  output logic                hit_pulse,
  output logic                miss_pulse,
  output logic [CNT_W-1:0]    hit_count,
  output logic [CNT_W-1:0]    miss_count
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int CTR_W  = (USE_STATES > 2) ? $clog2(USE_STATES) : 1;

  typedef logic [NUM_WAYS-1:0][TAG_W-1:0] set_tags_t;
  typedef logic [NUM_WAYS-1:0][CTR_W-1:0] set_ctrs_t;

  // command registers: zero means empty
  logic [ADDR_W-1:0] pf_q, iv_q, lk_q;
  logic              ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q    <= '0;
      iv_q    <= '0;
      lk_q    <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      pf_q    <= (fetch_valid && ready_q) ? fetch_addr : '0;
      iv_q    <= (inval_valid && ready_q) ? inval_addr : '0;
      lk_q    <= (lock_valid  && ready_q) ? lock_addr  : '0;
    end
  end
  assign cmd_ready = ready_q;

  logic pf_act, iv_act;
  assign pf_act = (pf_q != '0) && cache_present && cache_enable;
  assign iv_act = (iv_q != '0) && cache_present;

  logic [IDX_W-1:0] pf_set, iv_set;
  logic [TAG_W-1:0] pf_tag, iv_tag;

  icd_addr_split #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_split_pf (
    .line_addr(pf_q[ADDR_W-1:OFF_W]), .set_idx(pf_set), .tag(pf_tag));
  icd_addr_split #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_split_iv (
    .line_addr(iv_q[ADDR_W-1:OFF_W]), .set_idx(iv_set), .tag(iv_tag));

  set_tags_t tag_mem [NUM_SETS];
  set_ctrs_t ctr_mem [NUM_SETS];

  set_tags_t lk_tags, iv_base, iv_tags;
  set_ctrs_t lk_ctrs;
  lk_res_e   lk_res;

  icd_lookup #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .CTR_W(CTR_W),
               .USE_STATES(USE_STATES)) u_lookup (
    .tags_in(tag_mem[pf_set]), .ctrs_in(ctr_mem[pf_set]), .tag(pf_tag),
    .way_en(way_enable), .res(lk_res), .tags_out(lk_tags), .ctrs_out(lk_ctrs));

  // invalidate sees the lookup's result when both hit the same set
  assign iv_base = (pf_act && iv_set == pf_set) ? lk_tags : tag_mem[iv_set];

  icd_inval #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_inval (
    .tags_in(iv_base), .tag(iv_tag), .way_en(way_enable), .tags_out(iv_tags));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        tag_mem[s] <= '1;
        ctr_mem[s] <= '0;
      end
    end else begin
      if (pf_act) begin
        tag_mem[pf_set] <= lk_tags;
        ctr_mem[pf_set] <= lk_ctrs;
      end
      if (iv_act) tag_mem[iv_set] <= iv_tags;
    end
  end

  logic hit_now, miss_now;
  assign hit_now  = pf_act && (lk_res == LK_HIT);
  assign miss_now = pf_act && (lk_res == LK_MISS);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_pulse  <= 1'b0;
      miss_pulse <= 1'b0;
    end else begin
      hit_pulse  <= hit_now;
      miss_pulse <= miss_now;
    end
  end

  icd_sat_cnt #(.CNT_W(CNT_W)) u_hit_cnt  (.clk(clk), .rst(rst), .inc(hit_now),  .count(hit_count));
  icd_sat_cnt #(.CNT_W(CNT_W)) u_miss_cnt (.clk(clk), .rst(rst), .inc(miss_now), .count(miss_count));

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hit_pulse && miss_pulse)); // R8
  AST_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
    (hit_pulse || miss_pulse) |-> $past(pf_q != '0 && cache_present && cache_enable)); // R6
  AST_CMD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !(fetch_valid && cmd_ready) |=> (pf_q == '0)); // R8
  AST_LOCK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !(lock_valid && cmd_ready) |=> (lk_q == '0)); // R10
endmodule

// File: tb/test_icache_tag_dir.sv
module test_icache_tag_dir;
  localparam int NW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cache_present = 1'b1, cache_enable = 1'b1;
  logic [NW-1:0] way_enable = '1;
  logic fetch_valid = 1'b0, inval_valid = 1'b0, lock_valid = 1'b0;
  logic [31:0] fetch_addr = '0, inval_addr = '0, lock_addr = '0;
  logic cmd_ready, hit_pulse, miss_pulse;
  logic [31:0] hit_count, miss_count;
  logic s_ready, s_hit, s_miss;
  logic [1:0] s_hit_count, s_miss_count;

  always #10 clk = ~clk;

  icache_tag_dir #(.NUM_SETS(8), .LINE_BYTES(16), .NUM_WAYS(NW), .USE_STATES(2)) i_icache_tag_dir (
    .clk(clk), .rst(rst), .cache_present(cache_present), .cache_enable(cache_enable),
    .way_enable(way_enable), .cmd_ready(cmd_ready),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .inval_valid(inval_valid), .inval_addr(inval_addr),
    .lock_valid(lock_valid), .lock_addr(lock_addr),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
    .hit_count(hit_count), .miss_count(miss_count));

  icache_tag_dir #(.NUM_SETS(8), .LINE_BYTES(16), .NUM_WAYS(NW), .USE_STATES(2), .CNT_W(2)) i_icache_tag_dir_sat (
    .clk(clk), .rst(rst), .cache_present(cache_present), .cache_enable(cache_enable),
    .way_enable(way_enable), .cmd_ready(s_ready),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .inval_valid(inval_valid), .inval_addr(inval_addr),
    .lock_valid(lock_valid), .lock_addr(lock_addr),
    .hit_pulse(s_hit), .miss_pulse(s_miss),
    .hit_count(s_hit_count), .miss_count(s_miss_count));

  int n_checks = 0, n_fail = 0;
  int eh = 0, em = 0;

  // bit 32: expected hit; 8 sets x 16-byte lines: set = addr[6:4], tag = addr[31:7]
  localparam logic [32:0] VEC [13] = '{
    33'h0_00000090, 33'h1_00000090, 33'h0_00000110, 33'h1_00000090,
    33'h0_00000190, 33'h1_00000090, 33'h0_00000110, 33'h0_00000190,
    33'h1_00000110, 33'h0_00000090, 33'h1_0000009C, 33'h0_000000A0,
    33'h1_000000A4};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 = no pulse, 1 = hit, 2 = miss
  task automatic do_fetch(input logic [31:0] a, input int kind, input string req);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = '0;
    @(negedge clk);
    if (kind == 1) eh++;
    if (kind == 2) em++;
    check(hit_pulse == (kind == 1), req, hit_pulse, kind == 1);
    check(miss_pulse == (kind == 2), req, miss_pulse, kind == 2);
    check(hit_count == eh, req, hit_count, eh);
    check(miss_count == em, req, miss_count, em);
  endtask

  task automatic do_inval(input logic [31:0] a);
    inval_valid = 1'b1; inval_addr = a;
    @(negedge clk);
    inval_valid = 1'b0; inval_addr = '0;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R8 ready after reset
    check(hit_count == 0, "R1", hit_count, 0);
    check(miss_count == 0, "R1", miss_count, 0);
    check(!hit_pulse && !miss_pulse, "R1", {hit_pulse, miss_pulse}, 0);
    check(cmd_ready == 1'b1, "R8", cmd_ready, 1);

    // table walk: R1 first miss, R2 offset/set split, R3 hits, R4 victims
    for (int i = 0; i < 13; i++)
      do_fetch(VEC[i][31:0], VEC[i][32] ? 1 : 2, "R3/R4 table");

    // R8: pulse lasts one clock; zero address dropped
    @(negedge clk);
    check(!hit_pulse && !miss_pulse, "R8 width", {hit_pulse, miss_pulse}, 0);
    do_fetch(32'h0, 0, "R8 zero addr");

    // R6: gating by enable and present
    cache_enable = 1'b0;
    do_fetch(32'h0E0, 0, "R6 disabled");
    cache_enable = 1'b1;
    do_fetch(32'h0E0, 2, "R6 not installed");
    cache_present = 1'b0;
    do_fetch(32'h0E4, 0, "R6 absent");
    cache_present = 1'b1;

    // R7: invalidate gating (set1 holds tag 1 in way1)
    cache_present = 1'b0;
    do_inval(32'h090);
    cache_present = 1'b1;
    do_fetch(32'h090, 1, "R7 absent inval");
    way_enable = 2'b01;
    do_inval(32'h090);
    way_enable = 2'b11;
    do_fetch(32'h090, 1, "R7 masked inval");
    do_inval(32'h090);
    do_fetch(32'h090, 2, "R7 inval");

    // R5/R4: masked aging on set3
    do_fetch(32'h0B0, 2, "R5 setup");
    way_enable = 2'b01;
    do_fetch(32'h130, 2, "R5 masked miss");
    do_fetch(32'h1B0, 2, "R4 default way0");
    way_enable = 2'b11;
    do_fetch(32'h0B0, 1, "R5 way1 kept");
    do_fetch(32'h130, 2, "R4 evicted");

    // R3/R1: all-ones tag matches reset contents
    do_fetch(32'hFFFFFFC0, 1, "R3 all-ones tag");

    // R9: same-cycle lookup then invalidate on set5
    fetch_valid = 1'b1; fetch_addr = 32'h0D0;
    inval_valid = 1'b1; inval_addr = 32'h0D0;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = '0;
    inval_valid = 1'b0; inval_addr = '0;
    @(negedge clk);
    em++;
    check(miss_pulse == 1'b1, "R9 pulse", miss_pulse, 1);
    do_fetch(32'h0D0, 2, "R9 order");

    // R10: lock has no effect
    lock_valid = 1'b1; lock_addr = 32'h0D0;
    @(negedge clk);
    lock_valid = 1'b0; lock_addr = '0;
    @(negedge clk);
    check(!hit_pulse && !miss_pulse, "R10 no pulse", {hit_pulse, miss_pulse}, 0);
    check(hit_count == eh && miss_count == em, "R10 totals", hit_count, eh);
    do_fetch(32'h0D0, 1, "R10 still resident");

    // R11: narrow totals saturate
    check(s_hit_count == 2'd3, "R11 hit sat", s_hit_count, 3);
    check(s_miss_count == 2'd3, "R11 miss sat", s_miss_count, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule